// File: doc/BRIEF.md
# SDRAM Bank Precharge Timing Monitor

This block watches the command strobes of a four-bank SDRAM and keeps its own view of which banks hold an open row. At each rising clock edge it samples the chip-select, row strobe, column strobe and write-enable lines (all active low), address bit A10 and the two bank-select bits, and decodes one command. For every bank it runs small down-counters that track how soon the bank may be closed after a read or write burst and how soon it may be reopened after a close. The close can be explicit, or it can be automatic at the end of a burst.

Any command that breaks one of these windows, or that addresses a bank in the wrong state, raises a sticky violation flag. The flag comes with a 3-bit code naming the first broken rule. The monitor never drives the bus. It is placed beside a memory controller in simulation or in silicon to catch sequencing faults. Burst length, CAS latency and the three recovery times are parameters. The defaults are a burst of 4, a CAS latency of 3, a write recovery of 2, a precharge time of 3 and a write-with-auto-close recovery of 5 cycles.

Top module: `sdram_pc_monitor`

## Requirements
- R1: Commands are decoded from {ras_ni, cas_ni, we_ni} while cs_ni is 0: 011 activate, 101 read, 100 write, 010 precharge, 111 no-op. With cs_ni at 1, or with any other pattern, the command has no effect on bank state or on the violation outputs.
- R2: bank_open_o[b] is 1 from the edge after an activate to closed bank b until that bank is closed. After reset all bits are 0.
- R3: A precharge with a10_i at 0 closes only the bank selected by ba_i. With a10_i at 1 it closes every bank and ba_i is ignored. A precharge to a bank that is already closed has no effect.
- R4: After a write to bank b at cycle t, a precharge reaching that open bank before cycle t+BL-1+T_DPL is a violation with cause 1.
- R5: After a read to bank b at cycle t, a precharge reaching that open bank before cycle t+BL is a violation with cause 2. A precharge at t+BL is legal.
- R6: An activate to a closed bank earlier than T_RP cycles after that bank's precharge is a violation with cause 3. The bank still opens.
- R7: A read or write to a closed bank is a violation with cause 4 and leaves bank state unchanged.
- R8: An activate to a bank that is already open is a violation with cause 5 and leaves it open.
- R9: A read or write with a10_i at 1 to an open bank closes it at once. After a write of this kind at cycle t, the bank may be activated from t+BL-1+T_DAL. After a read of this kind, it may be activated from t+BL+T_RP. An earlier activate is cause 3.
- R10: viol_o and viol_cause_o are 0 after reset. They are set one edge after the first violating command and then hold their value until reset. If several causes arise in the same cycle, the lowest code is reported.
- R11: Each read or write to an open bank restarts that bank's close window with the rule of the latest access, replacing any window still running.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Command bus clock, sampled on the rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_ni | input | 1 | Chip select, active low |
| ras_ni | input | 1 | Row strobe, active low |
| cas_ni | input | 1 | Column strobe, active low |
| we_ni | input | 1 | Write enable, active low |
| a10_i | input | 1 | All-bank select on precharge; auto-close on read or write |
| ba_i | input | 2 | Bank select |
| bank_open_o | output | 4 | One bit per bank, 1 while the bank holds an open row |
| viol_o | output | 1 | Sticky violation flag |
| viol_cause_o | output | 3 | Code of the first violation (1 to 5), 0 when none |

## Verification
The case to watch is an all-bank precharge that arrives while one bank is still inside its write-recovery window and another is inside its read window. Both causes then arise in the same cycle, and the reported code must be the lower one, 1. The bench provokes this by issuing a write to bank 0 and a read to bank 1 on consecutive cycles, followed at once by an all-bank close. It then checks that both banks close and that cause 1 is latched. A later violation of a different kind in the same run must leave that code unchanged. A reference model in the bench, built on absolute cycle stamps, is compared with all outputs on every clock.

// File: rtl/sdram_pc_pkg.sv
package sdram_pc_pkg;

  typedef enum logic [2:0] {
    CMD_DESEL,
    CMD_NOP,
    CMD_ACT,
    CMD_RD,
    CMD_WR,
    CMD_PRE,
    CMD_OTHER
  } cmd_e;

  typedef enum logic [2:0] {
    CAUSE_NONE      = 3'd0,
    CAUSE_PRE_WR    = 3'd1,
    CAUSE_PRE_RD    = 3'd2,
    CAUSE_ACT_EARLY = 3'd3,
    CAUSE_CLOSED    = 3'd4,
    CAUSE_ACT_OPEN  = 3'd5
  } cause_e;

  typedef struct packed {
    logic pre_wr;
    logic pre_rd;
    logic act_early;
    logic closed;
    logic act_open;
  } err_t;

endpackage

// File: rtl/sdram_pc_decode.sv
module sdram_pc_decode
  import sdram_pc_pkg::*;
(
  input  logic cs_ni,
  input  logic ras_ni,
  input  logic cas_ni,
  input  logic we_ni,
  output cmd_e cmd_o
);

  always_comb begin
    if (cs_ni) begin
      cmd_o = CMD_DESEL;
    end else begin
      unique case ({ras_ni, cas_ni, we_ni})
        3'b011:  cmd_o = CMD_ACT;
        3'b101:  cmd_o = CMD_RD;
        3'b100:  cmd_o = CMD_WR;
        3'b010:  cmd_o = CMD_PRE;
        3'b111:  cmd_o = CMD_NOP;
        default: cmd_o = CMD_OTHER;  // refresh, mode set, burst stop
      endcase
    end
  end

endmodule

// File: rtl/sdram_pc_bank.sv
module sdram_pc_bank
  import sdram_pc_pkg::*;
#(
  parameter int BL    = 4,
  parameter int CL    = 3,
  parameter int T_DPL = 2,
  parameter int T_RP  = 3,
  parameter int T_DAL = 5
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  cmd_e cmd_i,
  input  logic sel_i,
  input  logic a10_i,
  output logic open_o,
  output err_t err_o
);

  // loads are (window length - 1): a counter at zero means the window is over
  localparam int WR_LD  = BL + T_DPL - 2;
  localparam int RD_LD  = (CL + BL - 1) - (CL - 1) - 1;
  localparam int PRE_LD = T_RP - 1;
  localparam int WAP_LD = BL + T_DAL - 2;
  localparam int RAP_LD = BL + T_RP - 1;
  localparam int G_MAX  = (WR_LD > RD_LD) ? WR_LD : RD_LD;
  localparam int R_MAX0 = (WAP_LD > RAP_LD) ? WAP_LD : RAP_LD;
  localparam int R_MAX  = (R_MAX0 > PRE_LD) ? R_MAX0 : PRE_LD;
  localparam int GW     = $clog2(G_MAX + 2);
  localparam int RW     = $clog2(R_MAX + 2);

  logic          open_q;
  logic [GW-1:0] guard_q;
  logic          guard_wr_q;
  logic [RW-1:0] rp_q;

  logic hit_pre, hit_act, hit_acc, is_wr;

  assign hit_pre = (cmd_i == CMD_PRE) && (a10_i || sel_i);
  assign hit_act = (cmd_i == CMD_ACT) && sel_i;
  assign is_wr   = (cmd_i == CMD_WR);
  assign hit_acc = ((cmd_i == CMD_RD) || is_wr) && sel_i;

  always_comb begin
    err_o           = '0;
    err_o.pre_wr    = hit_pre && open_q && (guard_q != '0) && guard_wr_q;
    err_o.pre_rd    = hit_pre && open_q && (guard_q != '0) && !guard_wr_q;
    err_o.act_early = hit_act && !open_q && (rp_q != '0);
    err_o.act_open  = hit_act && open_q;
    err_o.closed    = hit_acc && !open_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      open_q     <= 1'b0;
      guard_q    <= '0;
      guard_wr_q <= 1'b0;
      rp_q       <= '0;
    end else begin
      if (guard_q != '0) guard_q <= guard_q - 1'b1;
      if (rp_q != '0)    rp_q    <= rp_q - 1'b1;
      if (hit_pre && open_q) begin
        open_q  <= 1'b0;
        guard_q <= '0;
        rp_q    <= RW'(PRE_LD);
      end else if (hit_act && !open_q) begin
        open_q <= 1'b1;
      end else if (hit_acc && open_q) begin
        if (a10_i) begin
          open_q  <= 1'b0;
          guard_q <= '0;
          rp_q    <= is_wr ? RW'(WAP_LD) : RW'(RAP_LD);
        end else begin
          guard_q    <= is_wr ? GW'(WR_LD) : GW'(RD_LD);
          guard_wr_q <= is_wr;
        end
      end
    end
  end

  assign open_o = open_q;

  // a closed bank carries no running close window
  p_closed_no_guard_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !open_q |-> (guard_q == '0));

  p_pre_closes_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_pre |=> !open_q);

  p_act_opens_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit_act |=> open_q);

  p_auto_close_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_acc && open_q && a10_i) |=> (!open_q && (rp_q != '0)));

  p_closed_access_keeps_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (hit_acc && !open_q) |=> !open_q);

endmodule

// File: rtl/sdram_pc_viol.sv
module sdram_pc_viol
  import sdram_pc_pkg::*;
#(
  parameter int NUM_BANKS = 4
) (
  input  logic   clk_i,
  input  logic   rst_ni,
  input  err_t   err_i [NUM_BANKS],
  output logic   viol_o,
  output cause_e cause_o
);

  err_t   any_err;
  cause_e cause_d;
  logic   viol_q;
  cause_e cause_q;

  always_comb begin
    any_err = '0;
    for (int b = 0; b < NUM_BANKS; b++) any_err = any_err | err_i[b];
  end

  // lowest code wins
  always_comb begin
    if      (any_err.pre_wr)    cause_d = CAUSE_PRE_WR;
    else if (any_err.pre_rd)    cause_d = CAUSE_PRE_RD;
    else if (any_err.act_early) cause_d = CAUSE_ACT_EARLY;
    else if (any_err.closed)    cause_d = CAUSE_CLOSED;
    else if (any_err.act_open)  cause_d = CAUSE_ACT_OPEN;
    else                        cause_d = CAUSE_NONE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      viol_q  <= 1'b0;
      cause_q <= CAUSE_NONE;
    end else if (!viol_q && (cause_d != CAUSE_NONE)) begin
      viol_q  <= 1'b1;
      cause_q <= cause_d;
    end
  end

  assign viol_o  = viol_q;
  assign cause_o = cause_q;

  p_sticky_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_q |=> (viol_q && $stable(cause_q)));

  p_flag_matches_code_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    viol_q == (cause_q != CAUSE_NONE));

  p_first_latch_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!viol_q && (any_err != '0)) |=> viol_q);

endmodule

// File: rtl/sdram_pc_monitor.sv
module sdram_pc_monitor
  import sdram_pc_pkg::*;
#(
  parameter  int NUM_BANKS = 4,
  parameter  int BL        = 4,
  parameter  int CL        = 3,
  parameter  int T_DPL     = 2,
  parameter  int T_RP      = 3,
  parameter  int T_DAL     = 5,
  localparam int BA_W      = $clog2(NUM_BANKS)
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 cs_ni,
  input  logic                 ras_ni,
  input  logic                 cas_ni,
  input  logic                 we_ni,
  input  logic                 a10_i,
  input  logic [BA_W-1:0]      ba_i,
  output logic [NUM_BANKS-1:0] bank_open_o,
  output logic                 viol_o,
  output logic [2:0]           viol_cause_o
);

  cmd_e   cmd;
  err_t   bank_err [NUM_BANKS];
  cause_e cause;

  sdram_pc_decode u_decode (
    .cs_ni  (cs_ni),
    .ras_ni (ras_ni),
    .cas_ni (cas_ni),
    .we_ni  (we_ni),
    .cmd_o  (cmd)
  );

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    sdram_pc_bank #(
      .BL    (BL),
      .CL    (CL),
      .T_DPL (T_DPL),
      .T_RP  (T_RP),
      .T_DAL (T_DAL)
    ) u_bank (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .cmd_i  (cmd),
      .sel_i  (ba_i == BA_W'(g)),
      .a10_i  (a10_i),
      .open_o (bank_open_o[g]),
      .err_o  (bank_err[g])
    );
  end

  sdram_pc_viol #(
    .NUM_BANKS (NUM_BANKS)
  ) u_viol (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .err_i   (bank_err),
    .viol_o  (viol_o),
    .cause_o (cause)
  );

  assign viol_cause_o = cause;

  p_all_close_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!cs_ni && !ras_ni && cas_ni && !we_ni && a10_i) |=> (bank_open_o == '0));

  p_ignored_cmd_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cs_ni || (ras_ni && cas_ni && we_ni)) |=> $stable(bank_open_o));

endmodule

// File: tb/tb_sdram_pc_monitor.sv
`timescale 1ns/1ps
module tb_sdram_pc_monitor;

  localparam int BL = 4, CL = 3, T_DPL = 2, T_RP = 3, T_DAL = 5;
  localparam logic [2:0] K_ACT = 3'b011, K_RD = 3'b101, K_WR = 3'b100,
                         K_PRE = 3'b010, K_NOP = 3'b111;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b0, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1, a10 = 1'b0;
  logic [1:0] ba = 2'd0;
  logic [3:0] open_o;
  logic viol;
  logic [2:0] cause;

  always #2.5 clk = ~clk;

  sdram_pc_monitor #(.BL(BL), .CL(CL), .T_DPL(T_DPL), .T_RP(T_RP), .T_DAL(T_DAL)) dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_ni(cs_n), .ras_ni(ras_n), .cas_ni(cas_n),
    .we_ni(we_n), .a10_i(a10), .ba_i(ba), .bank_open_o(open_o),
    .viol_o(viol), .viol_cause_o(cause));

  int tests = 0, fails = 0;
  string cur_req = "R1";
  bit done = 0;

  // reference model on absolute cycle stamps
  int cyc;
  bit m_open [4];
  int m_pre_ok [4];
  int m_act_ok [4];
  bit m_wr [4];
  bit m_viol;
  int m_cause;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc = 0; m_viol = 0; m_cause = 0;
      for (int b = 0; b < 4; b++) begin
        m_open[b] = 0; m_pre_ok[b] = 0; m_act_ok[b] = 0; m_wr[b] = 0;
      end
    end else begin
      int errs;
      bit wr;
      errs = 0;
      cyc++;
      if (!cs_n) begin
        case ({ras_n, cas_n, we_n})
          K_PRE: for (int b = 0; b < 4; b++) begin
            if ((a10 || ba == b[1:0]) && m_open[b]) begin
              if (cyc < m_pre_ok[b]) errs |= m_wr[b] ? (1 << 1) : (1 << 2);
              m_open[b] = 0;
              m_act_ok[b] = cyc + T_RP;
            end
          end
          K_ACT: begin
            if (m_open[ba]) errs |= (1 << 5);
            else begin
              if (cyc < m_act_ok[ba]) errs |= (1 << 3);
              m_open[ba] = 1;
              m_pre_ok[ba] = 0;
            end
          end
          K_RD, K_WR: begin
            wr = !we_n;
            if (!m_open[ba]) errs |= (1 << 4);
            else if (a10) begin
              m_open[ba] = 0;
              m_act_ok[ba] = cyc + (wr ? BL - 1 + T_DAL : BL + T_RP);
            end else begin
              m_pre_ok[ba] = cyc + (wr ? BL - 1 + T_DPL : BL);
              m_wr[ba] = wr;
            end
          end
          default: ;
        endcase
      end
      if (!m_viol && errs != 0) begin
        m_viol = 1;
        for (int c = 5; c >= 1; c--) if (errs[c]) m_cause = c;
      end
    end
  end

  // per-cycle comparison
  always @(negedge clk) begin
    if (rst_n && !done) begin
      logic [7:0] exp_v, act_v;
      exp_v = {m_open[3], m_open[2], m_open[1], m_open[0], m_viol, 3'(m_cause)};
      act_v = {open_o, viol, cause};
      tests++;
      if (act_v !== exp_v) begin
        fails++;
        $display("FAIL %s model compare: actual %b expected %b", cur_req, act_v, exp_v);
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic issue(input logic [2:0] k, input logic [1:0] b, input logic a);
    @(negedge clk);
    cs_n = 1'b0; {ras_n, cas_n, we_n} = k; ba = b; a10 = a;
    @(posedge clk); #1;
    cs_n = 1'b0; {ras_n, cas_n, we_n} = K_NOP; a10 = 1'b0;
  endtask

  task automatic gap(input int k);
    if (k > 1) begin
      repeat (k - 1) @(posedge clk);
      #1;
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual running expected finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    do_reset();
    cur_req = "R10";
    #1;
    chk("R10 reset flag", viol, 0);
    chk("R10 reset cause", cause, 0);
    chk("R2 reset banks", open_o, 0);

    // R2 / R1
    cur_req = "R2";
    issue(K_ACT, 2'd0, 0); issue(K_ACT, 2'd2, 0);
    chk("R2 open after activate", open_o, 4'b0101);
    cur_req = "R1";
    @(negedge clk); cs_n = 1'b1; {ras_n, cas_n, we_n} = K_PRE; a10 = 1'b1;
    @(posedge clk); #1; cs_n = 1'b0; {ras_n, cas_n, we_n} = K_NOP; a10 = 1'b0;
    chk("R1 deselect ignored", open_o, 4'b0101);
    issue(K_NOP, 2'd2, 1);
    chk("R1 nop ignored", open_o, 4'b0101);
    chk("R1 no violation", viol, 0);

    // R3
    cur_req = "R3";
    issue(K_PRE, 2'd2, 0);
    chk("R3 single close", open_o, 4'b0001);
    issue(K_ACT, 2'd1, 0); issue(K_ACT, 2'd3, 0);
    issue(K_PRE, 2'd2, 1);
    chk("R3 all close", open_o, 0);
    gap(3); issue(K_PRE, 2'd0, 0);
    chk("R3 close of closed bank", viol, 0);

    // R4
    cur_req = "R4";
    do_reset(); issue(K_ACT, 2'd1, 0); issue(K_WR, 2'd1, 0); gap(4); issue(K_PRE, 2'd1, 0);
    chk("R4 early close after write", cause, 1);
    do_reset(); issue(K_ACT, 2'd1, 0); issue(K_WR, 2'd1, 0); gap(5); issue(K_PRE, 2'd1, 0);
    chk("R4 close at write boundary", viol, 0);
    chk("R4 bank closed", open_o, 0);

    // R5
    cur_req = "R5";
    do_reset(); issue(K_ACT, 2'd3, 0); issue(K_RD, 2'd3, 0); gap(3); issue(K_PRE, 2'd3, 0);
    chk("R5 early close after read", cause, 2);
    do_reset(); issue(K_ACT, 2'd3, 0); issue(K_RD, 2'd3, 0); gap(4); issue(K_PRE, 2'd3, 0);
    chk("R5 close at read boundary", viol, 0);

    // R6
    cur_req = "R6";
    do_reset(); issue(K_ACT, 2'd0, 0); issue(K_PRE, 2'd0, 0); gap(2); issue(K_ACT, 2'd0, 0);
    chk("R6 early activate", cause, 3);
    chk("R6 bank still opens", open_o, 4'b0001);
    do_reset(); issue(K_ACT, 2'd0, 0); issue(K_PRE, 2'd0, 0); gap(3); issue(K_ACT, 2'd0, 0);
    chk("R6 activate at boundary", viol, 0);

    // R7
    cur_req = "R7";
    do_reset(); issue(K_RD, 2'd2, 0);
    chk("R7 read closed bank", cause, 4);
    do_reset(); issue(K_ACT, 2'd1, 0); issue(K_WR, 2'd2, 0);
    chk("R7 write closed bank", cause, 4);
    chk("R7 state unchanged", open_o, 4'b0010);

    // R8
    cur_req = "R8";
    do_reset(); issue(K_ACT, 2'd1, 0); gap(3); issue(K_ACT, 2'd1, 0);
    chk("R8 activate open bank", cause, 5);
    chk("R8 stays open", open_o, 4'b0010);

    // R9
    cur_req = "R9";
    do_reset(); issue(K_ACT, 2'd0, 0); issue(K_WR, 2'd0, 1);
    chk("R9 write auto close", open_o, 0);
    gap(7); issue(K_ACT, 2'd0, 0);
    chk("R9 early activate after write auto close", cause, 3);
    do_reset(); issue(K_ACT, 2'd0, 0); issue(K_WR, 2'd0, 1); gap(8); issue(K_ACT, 2'd0, 0);
    chk("R9 write auto close boundary", viol, 0);
    do_reset(); issue(K_ACT, 2'd0, 0); issue(K_RD, 2'd0, 1); gap(6); issue(K_ACT, 2'd0, 0);
    chk("R9 early activate after read auto close", cause, 3);
    do_reset(); issue(K_ACT, 2'd0, 0); issue(K_RD, 2'd0, 1); gap(7); issue(K_ACT, 2'd0, 0);
    chk("R9 read auto close boundary", viol, 0);
    do_reset(); issue(K_ACT, 2'd2, 0); issue(K_RD, 2'd2, 1); issue(K_RD, 2'd2, 0);
    chk("R9 access after auto close", cause, 4);

    // R10: two causes in one cycle, then stickiness
    cur_req = "R10";
    do_reset(); issue(K_ACT, 2'd0, 0); issue(K_ACT, 2'd1, 0);
    issue(K_WR, 2'd0, 0); issue(K_RD, 2'd1, 0); issue(K_PRE, 2'd3, 1);
    chk("R10 lowest code wins", cause, 1);
    chk("R10 both closed", open_o, 0);
    issue(K_ACT, 2'd2, 0); issue(K_ACT, 2'd2, 0);
    chk("R10 first cause held", cause, 1);
    chk("R10 flag held", viol, 1);
    do_reset(); #1;
    chk("R10 reset clears", viol, 0);

    // R11
    cur_req = "R11";
    do_reset(); issue(K_ACT, 2'd0, 0); issue(K_RD, 2'd0, 0); issue(K_WR, 2'd0, 0);
    gap(4); issue(K_PRE, 2'd0, 0);
    chk("R11 write replaces read window", cause, 1);
    do_reset(); issue(K_ACT, 2'd0, 0); issue(K_WR, 2'd0, 0); gap(3); issue(K_RD, 2'd0, 0);
    gap(3); issue(K_PRE, 2'd0, 0);
    chk("R11 read replaces write window", cause, 2);

    gap(3);
    @(negedge clk);
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule